// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the drive codes for a four-common, eighteen-segment multiplexed liquid crystal panel, which holds up to 72 segments. Each pin gets a 2-bit level code every cycle, and an analog stage outside the block turns that code into a voltage. A 2 ms enable pulse steps the block through eight sub-phases. Each common owns two consecutive sub-phases of opposite polarity, so every segment sees zero average voltage, and a full frame lasts 16 ms (62.5 Hz).

Software writes a 72-bit staging register. The block copies it into the displayed register only when a frame ends, so a frame never shows a mix of old and new data. A bias input selects the 1/3 scheme (four levels on every pin) or the 1/2 scheme (three levels on commons, two on segments). A display-off input and the state that follows reset or a clock-stop exit both force the non-selected waveform. Every pin can instead be released to act as a plain output-port bit.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: A 3-bit sub-phase counter advances by one on each `tick` and wraps from 7 to 0. The active common is the counter's upper two bits, and the polarity is its lowest bit (0 = positive half, 1 = negative half).
- R2: Level codes are 00 ground, 01 one-third, 10 two-thirds (half supply in 1/2 bias), 11 full. With `bias_third`=1, the active common is driven to 11 in the positive half and 00 in the negative half. Every other common is driven to 01 in the positive half and 10 in the negative half.
- R3: With `bias_third`=1, a segment whose displayed bit is set is driven to 00 in the positive half and 11 in the negative half. A segment whose bit is clear is driven to 10 in the positive half and 01 in the negative half. Segment s under common c uses display bit c*18+s.
- R4: With `bias_third`=0, the active common is driven to 11 or 00 and the other commons to 10 in both halves. A set segment is driven to 00 or 11 and a clear segment to 11 or 00 (positive half or negative half), so a segment never carries 01 or 10.
- R5: A `wr_en` cycle loads `wr_data` into the staging register. The displayed register takes the staging value only on the `tick` that moves the counter from 7 to 0.
- R6: After reset, and after a `wake` pulse, the counter is 0 and every pin shows the non-selected waveform (no common active, every segment clear) until the first frame end. The displayed register keeps its contents across `wake`.
- R7: While `disp_off` is 1, every LCD pin shows the non-selected waveform at once. The sequencing continues underneath.
- R8: When a pin's port-enable bit is 1, that pin outputs 11 if its port value bit is 1 and 00 if it is 0. This holds whatever the bias, blanking or display-off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 2 ms sub-phase enable, one cycle wide |
| wake | input | 1 | Clock-stop exit pulse; restarts the frame blanked |
| bias_third | input | 1 | 1 = 1/3 bias, 0 = 1/2 bias |
| disp_off | input | 1 | Forces the non-selected waveform |
| wr_en | input | 1 | Staging register write strobe |
| wr_data | input | 72 | Segment pattern, bit c*18+s |
| com_port_en | input | 4 | Per-common port override enable |
| com_port_val | input | 4 | Per-common port value |
| seg_port_en | input | 18 | Per-segment port override enable |
| seg_port_val | input | 18 | Per-segment port value |
| com_code | output | 8 | Common level codes, common c at bits 2c+1:2c |
| seg_code | output | 36 | Segment level codes, segment s at bits 2s+1:2s |

## Verification
On every cycle the assertions check four things. The counter holds between ticks and steps by one on a tick. The displayed register never changes except at a frame end. A wake always leaves the counter at 0 and blanked. In 1/3 bias exactly one non-overridden common sits at an extreme level, display-off leaves none there, and 1/2 bias never puts an intermediate code on a segment. Only the bench scenarios show that the exact code on each pin matches the displayed pattern in all eight sub-phases for both biases. The same applies to a mid-frame write staying invisible until the frame ends, the blanked first frame after reset and after wake, and port overrides taking precedence.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef enum logic [1:0] {
        LVL_GND   = 2'b00,
        LVL_THIRD = 2'b01,
        LVL_MID   = 2'b10,
        LVL_FULL  = 2'b11
    } lvl_e;

    // Level for one pin given bias scheme, pin role, selection and polarity.
    function automatic lvl_e pick_level(input logic third, input logic is_com,
                                        input logic sel, input logic neg);
        lvl_e r;
        if (is_com) begin
            if (sel)        r = neg ? LVL_GND : LVL_FULL;
            else if (third) r = neg ? LVL_MID : LVL_THIRD;
            else            r = LVL_MID;
        end else begin
            if (sel)        r = neg ? LVL_FULL : LVL_GND;
            else if (third) r = neg ? LVL_THIRD : LVL_MID;
            else            r = neg ? LVL_GND : LVL_FULL;
        end
        return r;
    endfunction

endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
    parameter int N_COM = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          wake,
    output logic [$clog2(2*N_COM)-1:0]    phase,
    output logic                          blank,
    output logic                          frame_end
);
    localparam int PH_W = $clog2(2*N_COM);
    localparam logic [PH_W-1:0] LAST = PH_W'(2*N_COM-1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            blank;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wake) begin
            st_d.phase = '0;
            st_d.blank = 1'b1;
        end else if (tick) begin
            if (st_q.phase == LAST) begin
                st_d.phase = '0;
                st_d.blank = 1'b0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.blank <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.phase;
    assign blank     = st_q.blank;
    assign frame_end = tick && !wake && (st_q.phase == LAST);
endmodule

// File: rtl/lcd_frame_store.sv
module lcd_frame_store #(
    parameter int N_BITS = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [N_BITS-1:0] wr_data,
    input  logic              load,
    output logic [N_BITS-1:0] shown
);
    typedef struct packed {
        logic [N_BITS-1:0] staging;
        logic [N_BITS-1:0] shown;
    } fs_state_t;

    fs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)  st_d.shown   = st_q.staging;
        if (wr_en) st_d.staging = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shown = st_q.shown;
endmodule

// File: rtl/lcd_pin_encoder.sv
module lcd_pin_encoder
    import lcd_pkg::*;
#(
    parameter int N_PIN  = 4,
    parameter bit IS_COM = 1'b1
) (
    input  logic               bias_third,
    input  logic               neg,
    input  logic [N_PIN-1:0]   sel,
    input  logic [N_PIN-1:0]   port_en,
    input  logic [N_PIN-1:0]   port_val,
    output logic [2*N_PIN-1:0] code
);
    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
        assign code[2*i +: 2] = port_en[i] ? {2{port_val[i]}}
                                           : pick_level(bias_third, IS_COM, sel[i], neg);
    end
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer #(
    parameter int N_COM = 4,
    parameter int N_SEG = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   wake,
    input  logic                   bias_third,
    input  logic                   disp_off,
    input  logic                   wr_en,
    input  logic [N_COM*N_SEG-1:0] wr_data,
    input  logic [N_COM-1:0]       com_port_en,
    input  logic [N_COM-1:0]       com_port_val,
    input  logic [N_SEG-1:0]       seg_port_en,
    input  logic [N_SEG-1:0]       seg_port_val,
    output logic [2*N_COM-1:0]     com_code,
    output logic [2*N_SEG-1:0]     seg_code
);
    // N_COM must be a power of two so the phase splits into common index and polarity.
    localparam int N_BITS = N_COM * N_SEG;
    localparam int PH_W   = $clog2(2*N_COM);
    localparam int CW     = PH_W - 1;

    logic [PH_W-1:0]   phase;
    logic              blank;
    logic              frame_end;
    logic [N_BITS-1:0] shadow;
    logic [CW-1:0]     cur_com;
    logic              neg;
    logic              active;
    logic [N_COM-1:0]  com_sel;
    logic [N_SEG-1:0]  seg_row;
    logic [N_SEG-1:0]  seg_sel;

    lcd_timebase #(.N_COM(N_COM)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wake      (wake),
        .phase     (phase),
        .blank     (blank),
        .frame_end (frame_end)
    );

    lcd_frame_store #(.N_BITS(N_BITS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .load    (frame_end),
        .shown   (shadow)
    );

    assign cur_com = phase[PH_W-1:1];
    assign neg     = phase[0];
    assign active  = !blank && !disp_off;

    for (genvar c = 0; c < N_COM; c++) begin : g_csel
        assign com_sel[c] = active && (cur_com == CW'(c));
    end

    always_comb begin
        seg_row = '0;
        for (int c = 0; c < N_COM; c++) begin
            if (cur_com == CW'(c)) seg_row = shadow[c*N_SEG +: N_SEG];
        end
    end

    assign seg_sel = active ? seg_row : '0;

    lcd_pin_encoder #(.N_PIN(N_COM), .IS_COM(1'b1)) u_com_enc (
        .bias_third (bias_third),
        .neg        (neg),
        .sel        (com_sel),
        .port_en    (com_port_en),
        .port_val   (com_port_val),
        .code       (com_code)
    );

    lcd_pin_encoder #(.N_PIN(N_SEG), .IS_COM(1'b0)) u_seg_enc (
        .bias_third (bias_third),
        .neg        (neg),
        .sel        (seg_sel),
        .port_en    (seg_port_en),
        .port_val   (seg_port_val),
        .code       (seg_code)
    );
endmodule

// File: rtl/lcd_mux_sequencer_chk.sv
module lcd_mux_sequencer_chk #(
    parameter int N_COM = 4,
    parameter int N_SEG = 18
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick,
    input logic                          wake,
    input logic                          bias_third,
    input logic                          disp_off,
    input logic [N_COM-1:0]              com_port_en,
    input logic [N_SEG-1:0]              seg_port_en,
    input logic [2*N_COM-1:0]            com_code,
    input logic [2*N_SEG-1:0]            seg_code,
    input logic [$clog2(2*N_COM)-1:0]    phase_w,
    input logic                          blank_w,
    input logic [N_COM*N_SEG-1:0]        shadow_w
);
    localparam int PH_W = $clog2(2*N_COM);
    localparam logic [PH_W-1:0] LAST = PH_W'(2*N_COM-1);

    logic [N_COM-1:0] com_ext;
    logic [N_SEG-1:0] seg_mid;

    for (genvar c = 0; c < N_COM; c++) begin : g_cx
        assign com_ext[c] = (com_code[2*c +: 2] == 2'b00) || (com_code[2*c +: 2] == 2'b11);
    end
    for (genvar s = 0; s < N_SEG; s++) begin : g_sm
        assign seg_mid[s] = (seg_code[2*s +: 2] == 2'b01) || (seg_code[2*s +: 2] == 2'b10);
    end

    assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wake) |=> $stable(phase_w));

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wake && phase_w != LAST) |=> (phase_w == $past(phase_w) + 1'b1));

    assert_one_active_com_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_third && com_port_en == '0 && !blank_w && !disp_off) |-> ($countones(com_ext) == 1));

    assert_half_bias_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bias_third) |-> ((seg_mid & ~seg_port_en) == '0));

    assert_frame_only_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && !wake && phase_w == LAST) |=> $stable(shadow_w));

    assert_wake_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (phase_w == '0 && blank_w));

    assert_off_no_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_off && com_port_en == '0) |-> (com_ext == '0));
endmodule

bind lcd_mux_sequencer lcd_mux_sequencer_chk #(.N_COM(N_COM), .N_SEG(N_SEG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .wake        (wake),
    .bias_third  (bias_third),
    .disp_off    (disp_off),
    .com_port_en (com_port_en),
    .seg_port_en (seg_port_en),
    .com_code    (com_code),
    .seg_code    (seg_code),
    .phase_w     (phase),
    .blank_w     (blank),
    .shadow_w    (shadow)
);

// File: tb/lcd_mux_sequencer_bench.sv
module lcd_mux_sequencer_bench;
    localparam int NC = 4;
    localparam int NS = 18;
    localparam int NB = NC * NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, wake = 1'b0, bias_third = 1'b1, disp_off = 1'b0, wr_en = 1'b0;
    logic [NB-1:0]   wr_data = '0;
    logic [NC-1:0]   com_port_en = '0, com_port_val = '0;
    logic [NS-1:0]   seg_port_en = '0, seg_port_val = '0;
    logic [2*NC-1:0] com_code;
    logic [2*NS-1:0] seg_code;

    int errors = 0;
    int checks = 0;

    // Bench-side model state
    int            m_phase = 0;
    bit            m_blank = 1'b1;
    logic [NB-1:0] m_shown = '0;
    logic [NB-1:0] m_stage = '0;

    // {bias_third, disp_off, expected com_code at sub-phase 0, pattern}
    localparam logic [81:0] VECS [6] = '{
        {1'b1, 1'b0, 8'h57, {72{1'b1}}},
        {1'b0, 1'b0, 8'hAB, {18{4'hA}}},
        {1'b1, 1'b0, 8'h57, 72'h123456789ABCDEF012},
        {1'b0, 1'b0, 8'hAB, {36{2'b01}}},
        {1'b1, 1'b1, 8'h55, {72{1'b1}}},
        {1'b0, 1'b1, 8'hAA, 72'h0}
    };

    lcd_mux_sequencer u_lcd_mux_sequencer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wake(wake),
        .bias_third(bias_third), .disp_off(disp_off),
        .wr_en(wr_en), .wr_data(wr_data),
        .com_port_en(com_port_en), .com_port_val(com_port_val),
        .seg_port_en(seg_port_en), .seg_port_val(seg_port_val),
        .com_code(com_code), .seg_code(seg_code)
    );

    always #2 clk = ~clk;

    function automatic logic [1:0] want(input bit third, input bit is_com, input bit sel, input bit neg);
        if (is_com && sel)  return neg ? 2'd0 : 2'd3;
        if (is_com)         return third ? (neg ? 2'd2 : 2'd1) : 2'd2;
        if (sel)            return neg ? 2'd3 : 2'd0;
        if (third)          return neg ? 2'd1 : 2'd2;
        return neg ? 2'd0 : 2'd3;
    endfunction

    task automatic check_now(input string tag);
        logic [2*NC-1:0] ec;
        logic [2*NS-1:0] es;
        bit on;
        int cur;
        #1;
        cur = m_phase / 2;
        on  = !m_blank && !disp_off;
        for (int c = 0; c < NC; c++)
            ec[2*c +: 2] = com_port_en[c] ? {2{com_port_val[c]}}
                                          : want(bias_third, 1'b1, on && (c == cur), m_phase[0]);
        for (int s = 0; s < NS; s++)
            es[2*s +: 2] = seg_port_en[s] ? {2{seg_port_val[s]}}
                                          : want(bias_third, 1'b0, on && m_shown[cur*NS + s], m_phase[0]);
        checks++;
        if (com_code !== ec || seg_code !== es) begin
            errors++;
            $display("FAIL %s phase=%0d: com=%h seg=%h expected com=%h seg=%h",
                     tag, m_phase, com_code, seg_code, ec, es);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        if (m_phase == 7) begin
            m_phase = 0; m_blank = 1'b0; m_shown = m_stage;
        end else begin
            m_phase++;
        end
    endtask

    task automatic do_write(input logic [NB-1:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
        m_stage = d;
    endtask

    task automatic do_wake();
        @(negedge clk) wake = 1'b1;
        @(negedge clk) wake = 1'b0;
        m_phase = 0; m_blank = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [81:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        check_now("R6 reset non-selected");
        do_write({72{1'b1}});
        check_now("R6 write while blanked");
        repeat (7) do_tick();
        check_now("R6 blank through phase 7");
        do_tick();
        check_now("R5 R6 first frame shows staged data");

        for (int k = 0; k < 6; k++) begin
            v = VECS[k];
            bias_third = v[81];
            disp_off   = v[80];
            do_write(v[71:0]);
            repeat (8) do_tick();
            for (int p = 0; p < 8; p++) begin
                if (disp_off)        check_now("R1 R7 sweep");
                else if (bias_third) check_now("R1 R2 R3 sweep");
                else                 check_now("R1 R4 sweep");
                if (p == 0) begin
                    checks++;
                    if (com_code !== v[79:72]) begin
                        errors++;
                        $display("FAIL R2 R4 R7 table com: got %h expected %h", com_code, v[79:72]);
                    end
                end
                do_tick();
            end
        end

        bias_third = 1'b1; disp_off = 1'b0;
        do_write(72'hF0F0_0F0F_AAAA_5555_C3);
        do_tick(); do_tick();
        check_now("R5 mid-frame write not yet shown");
        repeat (6) do_tick();
        check_now("R5 new data at frame start");

        do_tick(); do_tick();
        disp_off = 1'b1;
        check_now("R7 display off immediate");
        disp_off = 1'b0;
        check_now("R7 display restored");

        com_port_en = 4'b0101; com_port_val = 4'b0001;
        seg_port_en = 18'h20001; seg_port_val = 18'h20000;
        check_now("R8 port override");
        disp_off = 1'b1; bias_third = 1'b0;
        check_now("R8 override under display off");
        disp_off = 1'b0; bias_third = 1'b1;
        com_port_en = '0; seg_port_en = '0;

        do_tick();
        do_wake();
        check_now("R6 wake restarts blanked");
        do_tick();
        check_now("R1 R6 still blanked after wake");
        repeat (7) do_tick();
        check_now("R6 display returns after wake frame");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule